// File: doc/BRIEF.md
# Shared-Pool Wallace Gaussian Sample Generator

This block produces a continuous stream of approximately Gaussian fixed-point samples without multipliers or random address generation. It contains a ring of generator units. Each unit owns a small pool memory that is filled beforehand with Gaussian samples. On every transfer, a unit takes four consecutive pool entries as x1..x4. It forms half of their sum, t. From t it derives four new samples: t-x1, t-x2, x3-t and x4-t. These four samples leave on the output bus.

The same samples are also written back into the pool row they came from. Before the write-back, the combined vector of all units is rotated by one lane position. As a result, each pool absorbs one value produced by its neighbour, and the small pools behave like one large shared pool.

A preload port fills the pools before generation starts. Generation is requested with `gen_en`. The output is a valid/ready stream carrying four samples per unit.

Back-pressure rules:
- A transfer happens on a rising clock edge where `out_valid` and `out_ready` are both high.
- While `out_valid` is high and `out_ready` is low, `out_data` holds its value and nothing advances.
- A pool row is written back only when its output is transferred.

Preloading is meant for times when `gen_en` is low and `out_valid` is low. In a cycle where a write-back and a preload hit the same unit, the write-back takes priority.

Top module: `wal_gauss_gen`

## Requirements
- R1: After reset, fetches read pool rows in order 0, 1, 2, ... and wrap to row 0 after row POOL_DEPTH/4-1. Row r supplies entries 4r, 4r+1, 4r+2 and 4r+3 as x1, x2, x3 and x4.
- R2: The sum x1+x2+x3+x4 is formed in SAMPLE_W+2 bits, and t is that sum shifted right by one bit with sign extension (rounding toward minus infinity).
- R3: Unit u outputs y1=t-x1, y2=t-x2, y3=x3-t and y4=x4-t, each reduced to SAMPLE_W-bit two's complement (wrapping). Output yk+1 of unit u appears at `out_data[(4u+k)*SAMPLE_W +: SAMPLE_W]`, for k from 0 to 3.
- R4: On a transfer, the rows just read are overwritten with the output vector rotated by one lane:
  - Lane k>0 of unit u receives that unit's output yk.
  - Lane 0 of unit u receives y4 of unit u-1.
  - Lane 0 of unit 0 receives y4 of the last unit.
- R5: A fetch of the row that is being written back in the same cycle returns the newly written values. This case occurs when a pool holds a single row.
- R6: `out_valid` rises one cycle after `gen_en` is sampled high while the stage is empty. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R7: While `gen_en` is low, no row is fetched. `out_valid` falls after the last transfer, and a later resumption continues from the next unread row.
- R8: Reset clears `out_valid` and returns the row pointer to row 0. Reset does not change the pool contents.
- R9: When `load_en` is high, `load_data` is written into entry `load_addr` of unit `load_unit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Pool preload strobe |
| load_unit | input | max(1,clog2(NUM_UNITS)) | Unit whose pool is preloaded |
| load_addr | input | clog2(POOL_DEPTH) | Pool entry index |
| load_data | input | SAMPLE_W | Preload sample, two's complement |
| gen_en | input | 1 | Generation request |
| out_ready | input | 1 | Consumer ready |
| out_valid | output | 1 | Output samples valid |
| out_data | output | NUM_UNITS*4*SAMPLE_W | Four samples per unit, unit 0 in the low bits |

## Verification
The bench builds two instances of the block.

The first instance has three units and 8-entry pools, giving two rows per pool. With this setting, a short run wraps the row pointer several times. It also sends values around a three-unit ring, including the wrap from the last unit to the first. Every output is compared against a bench model of the pools.

The second instance has two units and 4-entry pools, giving a single row per pool. Here every fetch collides with the write-back of the same row, which exercises the read-after-write forwarding on every cycle.

// File: rtl/wal_pkg.sv
package wal_pkg;
  // Number of samples each unit consumes and produces per transfer.
  localparam int LANES = 4;

  // Index of the ring neighbour that feeds a given lane position.
  function automatic int ring_prev(int idx, int total);
    return (idx == 0) ? total - 1 : idx - 1;
  endfunction
endpackage

// File: rtl/wal_row_ctrl.sv
module wal_row_ctrl #(
  parameter int ROWS  = 64,
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             fetch,
  output logic             fire,
  output logic [ROW_W-1:0] rd_row,
  output logic [ROW_W-1:0] wb_row
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic             stage_full;
  logic             advance;
  logic [ROW_W-1:0] rd_ptr;
  logic [ROW_W-1:0] rd_next;

  assign advance   = !stage_full || out_ready;
  assign fire      = stage_full && out_ready;
  assign fetch     = advance && gen_en;
  assign rd_next   = (rd_ptr == LAST_ROW) ? '0 : rd_ptr + 1'b1;
  assign out_valid = stage_full;
  assign rd_row    = rd_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_full <= 1'b0;
      rd_ptr     <= '0;
      wb_row     <= '0;
    end else if (advance) begin
      stage_full <= gen_en;
      if (gen_en) begin
        wb_row <= rd_ptr;
        rd_ptr <= rd_next;
      end
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch |=> $stable(rd_ptr)); // R7

  AST_VALID_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!stage_full && gen_en) |=> stage_full); // R6

  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stage_full) |-> $past(fire)); // R7
endmodule

// File: rtl/wal_pool.sv
module wal_pool #(
  parameter int W     = 8,
  parameter int ROWS  = 64,
  parameter int ROW_W = 6
) (
  input  logic                          clk,
  input  logic                          load_en,
  input  logic [ROW_W-1:0]              load_row,
  input  logic [1:0]                    load_lane,
  input  logic [W-1:0]                  load_data,
  input  logic                          wr_en,
  input  logic [ROW_W-1:0]              wr_row,
  input  logic [wal_pkg::LANES*W-1:0]   wr_data,
  input  logic                          fetch,
  input  logic [ROW_W-1:0]              rd_row,
  output logic [wal_pkg::LANES*W-1:0]   x_q
);
  localparam int LANES = wal_pkg::LANES;
  localparam int SLOTS = 1 << ROW_W;

  logic row_hit;
  assign row_hit = wr_en && (wr_row == rd_row);

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [W-1:0] mem [SLOTS];
    logic [W-1:0] rd_word;

    always_ff @(posedge clk) begin
      if (wr_en) begin
        mem[wr_row] <= wr_data[b*W +: W];
      end else if (load_en && (load_lane == 2'(b))) begin
        mem[load_row] <= load_data;
      end
    end

    // Forward the write-back when the same row is fetched in this cycle.
    assign rd_word = row_hit ? wr_data[b*W +: W] : mem[rd_row];

    always_ff @(posedge clk) begin
      if (fetch) begin
        x_q[b*W +: W] <= rd_word;
      end
    end
  end
endmodule

// File: rtl/wal_hadamard4.sv
module wal_hadamard4 #(
  parameter int W = 8
) (
  input  logic [wal_pkg::LANES*W-1:0] x_flat,
  output logic [wal_pkg::LANES*W-1:0] y_flat
);
  localparam int LANES = wal_pkg::LANES;
  localparam int SW    = W + 2;

  logic signed [SW-1:0] xs [LANES];
  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] half;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      xs[k] = SW'($signed(x_flat[k*W +: W]));
    end
    sum  = xs[0] + xs[1] + xs[2] + xs[3];
    half = sum >>> 1;
    y_flat[0*W +: W] = W'(half - xs[0]);
    y_flat[1*W +: W] = W'(half - xs[1]);
    y_flat[2*W +: W] = W'(xs[2] - half);
    y_flat[3*W +: W] = W'(xs[3] - half);
  end
endmodule

// File: rtl/wal_rotate.sv
module wal_rotate #(
  parameter int W         = 8,
  parameter int NUM_UNITS = 8
) (
  input  logic [NUM_UNITS*wal_pkg::LANES*W-1:0] gen_flat,
  output logic [NUM_UNITS*wal_pkg::LANES*W-1:0] wb_flat
);
  localparam int TOTAL = NUM_UNITS * wal_pkg::LANES;

  for (genvar i = 0; i < TOTAL; i++) begin : g_slot
    localparam int SRC = wal_pkg::ring_prev(i, TOTAL);
    assign wb_flat[i*W +: W] = gen_flat[SRC*W +: W];
  end
endmodule

// File: rtl/wal_gauss_gen.sv
module wal_gauss_gen #(
  parameter int SAMPLE_W   = 8,
  parameter int NUM_UNITS  = 8,
  parameter int POOL_DEPTH = 256
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        load_en,
  input  logic [(NUM_UNITS > 1 ? $clog2(NUM_UNITS) : 1)-1:0] load_unit,
  input  logic [$clog2(POOL_DEPTH)-1:0]               load_addr,
  input  logic [SAMPLE_W-1:0]                         load_data,
  input  logic                                        gen_en,
  input  logic                                        out_ready,
  output logic                                        out_valid,
  output logic [NUM_UNITS*wal_pkg::LANES*SAMPLE_W-1:0] out_data
);
  localparam int LANES  = wal_pkg::LANES;
  localparam int W      = SAMPLE_W;
  localparam int ROWS   = POOL_DEPTH / LANES;
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam int UW     = LANES * W;
  localparam int BUS_W  = NUM_UNITS * UW;

  logic             fetch;
  logic             fire;
  logic [ROW_W-1:0] rd_row;
  logic [ROW_W-1:0] wb_row;
  logic [ROW_W-1:0] load_row;
  logic [1:0]       load_lane;
  logic [BUS_W-1:0] x_all;
  logic [BUS_W-1:0] gen_flat;
  logic [BUS_W-1:0] wb_flat;

  assign load_row  = ROW_W'(load_addr >> 2);
  assign load_lane = load_addr[1:0];

  wal_row_ctrl #(.ROWS(ROWS), .ROW_W(ROW_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen_en   (gen_en),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .fetch    (fetch),
    .fire     (fire),
    .rd_row   (rd_row),
    .wb_row   (wb_row)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic sel_load;
    assign sel_load = load_en && (load_unit == UNIT_W'(u));

    wal_pool #(.W(W), .ROWS(ROWS), .ROW_W(ROW_W)) u_pool (
      .clk      (clk),
      .load_en  (sel_load),
      .load_row (load_row),
      .load_lane(load_lane),
      .load_data(load_data),
      .wr_en    (fire),
      .wr_row   (wb_row),
      .wr_data  (wb_flat[u*UW +: UW]),
      .fetch    (fetch),
      .rd_row   (rd_row),
      .x_q      (x_all[u*UW +: UW])
    );

    wal_hadamard4 #(.W(W)) u_had (
      .x_flat(x_all[u*UW +: UW]),
      .y_flat(gen_flat[u*UW +: UW])
    );

    // y1 - y2 must equal x2 - x1, and y3 - y4 must equal x3 - x4.
    AST_LANE_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |->
        (W'(gen_flat[u*UW +: W] - gen_flat[u*UW + W +: W]) ==
         W'(x_all[u*UW + W +: W] - x_all[u*UW +: W])) &&
        (W'(gen_flat[u*UW + 2*W +: W] - gen_flat[u*UW + 3*W +: W]) ==
         W'(x_all[u*UW + 2*W +: W] - x_all[u*UW + 3*W +: W]))); // R3
  end

  wal_rotate #(.W(W), .NUM_UNITS(NUM_UNITS)) u_rot (
    .gen_flat(gen_flat),
    .wb_flat (wb_flat)
  );

  assign out_data = gen_flat;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
endmodule

// File: tb/tb_wal_gauss_gen.sv
`timescale 1ns/1ps
module tb_wal_gauss_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // Instance A: 3 units, 8-entry pools (2 rows)
  logic        a_load_en = 0;
  logic [1:0]  a_load_unit = 0;
  logic [2:0]  a_load_addr = 0;
  logic [7:0]  a_load_data = 0;
  logic        a_gen = 0, a_rdy = 0, a_valid;
  logic [95:0] a_out;
  // Instance B: 2 units, 4-entry pools (1 row)
  logic        b_load_en = 0;
  logic [0:0]  b_load_unit = 0;
  logic [1:0]  b_load_addr = 0;
  logic [7:0]  b_load_data = 0;
  logic        b_gen = 0, b_rdy = 0, b_valid;
  logic [63:0] b_out;

  wal_gauss_gen #(.SAMPLE_W(8), .NUM_UNITS(3), .POOL_DEPTH(8)) dut (
    .clk(clk), .rst_n(rst_n), .load_en(a_load_en), .load_unit(a_load_unit),
    .load_addr(a_load_addr), .load_data(a_load_data), .gen_en(a_gen),
    .out_ready(a_rdy), .out_valid(a_valid), .out_data(a_out));

  wal_gauss_gen #(.SAMPLE_W(8), .NUM_UNITS(2), .POOL_DEPTH(4)) dut_one (
    .clk(clk), .rst_n(rst_n), .load_en(b_load_en), .load_unit(b_load_unit),
    .load_addr(b_load_addr), .load_data(b_load_data), .gen_en(b_gen),
    .out_ready(b_rdy), .out_valid(b_valid), .out_data(b_out));

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  // x1..x4 followed by expected y1..y4 for unit 0
  localparam int VEC [8][8] = '{
    '{  10,  20,  30,  40,   40,   30,  -20,  -10},
    '{ -10, -20, -30, -40,  -40,  -30,   20,   10},
    '{   1,   2,   4,   8,    6,    5,   -3,    1},
    '{  -1,   0,   0,   0,    0,   -1,    1,    1},
    '{ 127, 127, 127, 127,  127,  127, -127, -127},
    '{-128,-128,-128,-128, -128, -128, -128, -128},
    '{ 100,-100,  50, -50, -100,  100,   50,  -50},
    '{   3,   0,   0,   0,   -2,    1,   -1,   -1}
  };

  // Bench model of the pools: [instance][unit][entry]
  int mp [2][3][8];
  int mnu [2] = '{3, 2};
  int mrows [2] = '{2, 1};
  int mrd [2] = '{0, 0};

  function automatic int wrap8(int v);
    int m = v & 255;
    if (m > 127) m -= 256;
    return m;
  endfunction

  function automatic int exp_y(int i, int u, int k);
    int x [4];
    int s, t;
    for (int j = 0; j < 4; j++) x[j] = mp[i][u][mrd[i]*4 + j];
    s = x[0] + x[1] + x[2] + x[3];
    t = s >>> 1;
    case (k)
      0: return wrap8(t - x[0]);
      1: return wrap8(t - x[1]);
      2: return wrap8(x[2] - t);
      default: return wrap8(x[3] - t);
    endcase
  endfunction

  task automatic commit(int i);
    int f [12];
    int tot = mnu[i] * 4;
    for (int u = 0; u < mnu[i]; u++)
      for (int k = 0; k < 4; k++) f[u*4 + k] = exp_y(i, u, k);
    for (int u = 0; u < mnu[i]; u++)
      for (int k = 0; k < 4; k++)
        mp[i][u][mrd[i]*4 + k] = f[(u*4 + k == 0) ? tot - 1 : u*4 + k - 1];
    mrd[i] = (mrd[i] + 1) % mrows[i];
  endtask

  function automatic int get_out(int i, int u, int k);
    if (i == 0) return wrap8(int'(a_out[(u*4 + k)*8 +: 8]));
    return wrap8(int'(b_out[(u*4 + k)*8 +: 8]));
  endfunction

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; a_gen = 0; b_gen = 0; a_rdy = 0; b_rdy = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic preload(int i, int u, int addr, int val);
    if (i == 0) begin
      a_load_en = 1; a_load_unit = 2'(u); a_load_addr = 3'(addr); a_load_data = 8'(val);
    end else begin
      b_load_en = 1; b_load_unit = 1'(u); b_load_addr = 2'(addr); b_load_data = 8'(val);
    end
    @(negedge clk);
    a_load_en = 0; b_load_en = 0;
  endtask

  // At a falling edge: compare outputs with the model, drive ready/enable, advance.
  task automatic step(int i, int r, int g, string tag);
    logic v = (i == 0) ? a_valid : b_valid;
    if (v)
      for (int u = 0; u < mnu[i]; u++)
        for (int k = 0; k < 4; k++) check(tag, get_out(i, u, k), exp_y(i, u, k));
    if (i == 0) begin a_rdy = 1'(r); a_gen = 1'(g); end
    else        begin b_rdy = 1'(r); b_gen = 1'(g); end
    if (v && r != 0) commit(i);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8: stage empty after reset
    check("R8 reset valid A", int'(a_valid), 0);
    check("R8 reset valid B", int'(b_valid), 0);

    // Table of transform vectors through unit 0, row 0
    for (int v = 0; v < 8; v++) begin
      do_reset();
      for (int j = 0; j < 4; j++) preload(0, 0, j, VEC[v][j]);
      a_gen = 1; a_rdy = 1;
      @(negedge clk);
      check("R6 valid after enable", int'(a_valid), 1);
      for (int k = 0; k < 4; k++)
        check("R2 R3 R9 vector", get_out(0, 0, k), VEC[v][4 + k]);
      a_gen = 0;
      @(negedge clk);
      check("R7 drain after transfer", int'(a_valid), 0);
    end

    // Model-checked run on instance A
    do_reset();
    for (int u = 0; u < 3; u++)
      for (int e = 0; e < 8; e++) begin
        mp[0][u][e] = wrap8(u*37 + e*23 + 5 - (e % 3) * 90);
        preload(0, u, e, mp[0][u][e]);
      end
    mrd[0] = 0;
    repeat (6) step(0, 1, 1, "R1 R4 model");
    for (int s = 0; s < 3; s++) begin
      check("R6 stall valid", int'(a_valid), 1);
      step(0, 0, 1, "R6 stall hold");
    end
    step(0, 1, 0, "R4 last transfer");
    check("R7 idle valid low", int'(a_valid), 0);
    step(0, 1, 0, "R7 idle");
    check("R7 still idle", int'(a_valid), 0);
    step(0, 1, 0, "R7 idle");
    repeat (4) step(0, 1, 1, "R7 resume");
    step(0, 1, 0, "R7 drain");
    step(0, 1, 0, "R7 drain");

    // R8: reset restarts at row 0 with pool contents kept
    do_reset();
    mrd[0] = 0;
    repeat (4) step(0, 1, 1, "R8 restart");
    step(0, 1, 0, "R8 drain");
    step(0, 1, 0, "R8 drain");

    // Instance B: single-row pools, every fetch collides with a write-back
    for (int u = 0; u < 2; u++)
      for (int e = 0; e < 4; e++) begin
        mp[1][u][e] = wrap8(u*61 - e*29 + 17);
        preload(1, u, e, mp[1][u][e]);
      end
    mrd[1] = 0;
    repeat (6) step(1, 1, 1, "R5 bypass");
    step(1, 1, 0, "R5 drain");
    step(1, 1, 0, "R5 drain");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nerr++;
      $display("FAIL R6 watchdog timeout: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule